// File: doc/BRIEF.md
# Asynchronous Bus Cycle Sequencer

This block is the bus-master side of an external memory interface. A core hands it one transfer at a time: a direction, an address and, for writes, a data word. It runs the transfer on the external pins as a series of half-clock states. One internal clock tick stands for one half-state. It drives the address strobe, the data strobe and the read/write line. It waits for a slave acknowledge or a bus error, then returns a one-tick completion pulse with an error flag and, on reads, the captured data.

The address space is split into regions, selected by the top address bits. Each region has three static configuration settings:

- **Fast termination:** the block acknowledges the region itself in four ticks.
- **Internal acknowledge:** the block acknowledges the region itself after a programmed number of wait-state pairs.
- **Neither:** the region depends only on the external acknowledge.

The acknowledge and error pins are asynchronous and pass through a two-flop synchronizer before any decision uses them.

**States:**

- `ST_IDLE` waits for a request.
- `ST_S0` latches the request.
- `ST_S1` asserts the address strobe.
- `ST_S2` is the first termination decision point.
- `ST_SW1` and `ST_SW2` form one wait-state pair. `ST_SW2` is a further decision point.
- `ST_S3` and `ST_S4` hold the strobes. The read data is captured as `ST_S4` ends.
- `ST_S5` negates the strobes and signals completion.

**Transitions:**

- `ST_IDLE` goes to `ST_S0` on a request.
- `ST_S0` goes to `ST_S1`.
- `ST_S1` goes to `ST_S4` for a fast region and to `ST_S2` otherwise.
- `ST_S2` and `ST_SW2` go to `ST_S3` when a termination is seen, and to `ST_SW1` when it is not.
- `ST_SW1` goes to `ST_SW2`.
- `ST_S3` goes to `ST_S4`, `ST_S4` goes to `ST_S5`, and `ST_S5` goes to `ST_IDLE`.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset `bus_as_n`, `bus_ds_n` and `bus_rw` are 1, `done` is 0 and `req_ready` is 1.
- R2: A non-fast cycle lasts 6+2k ticks, from the S0 tick to the S5 tick inclusive. Here k is the number of wait-state pairs, and a pair is added at each decision point (S2, then each second wait tick) at which no termination is seen.
- R3: `bus_ack_n` and `bus_berr_n` (active low) reach the decision logic through two flops. A level driven during tick t can first terminate the cycle at a decision point in tick t+2 or later.
- R4: In a region with internal acknowledge and wait count N (field of WW bits at `cfg_waits[r*WW +: WW]`), the cycle has exactly N wait-state pairs with no external acknowledge. N=0 gives six ticks.
- R5: A synchronized bus error seen at a decision point ends the waiting, with or without an acknowledge, and the cycle completes with `done_err`=1.
- R6: A synchronized bus error first seen in the S3 or S4 tick, after the acknowledge, also gives `done_err`=1. A bus error first seen after S4 gives `done_err`=0.
- R7: In a fast region (`cfg_fast[r]`=1, where r is `req_addr[AW-1 -: log2(NREG)]`), the cycle is S0,S1,S4,S5, four ticks long. It ignores the region's wait count and the external acknowledge and error pins, and `done_err` is 0.
- R8: `bus_as_n` is low in S1, S2, the wait ticks, S3 and S4.
  - On a normal read, `bus_ds_n` is low in the same ticks as `bus_as_n`.
  - On a normal write, `bus_ds_n` is low only in S3 and S4.
  - On a fast read, `bus_ds_n` is low in S1 and S4.
  - On a fast write, `bus_ds_n` never goes low.
- R9: During a write, `bus_rw` is 0 from S0 through S5, and `bus_dout_en` is 1 with `bus_dout` equal to the write data whenever `bus_ds_n` is low. During a read, `bus_rw` stays 1.
- R10: On reads, `rd_data` holds `bus_din` as sampled at the end of the S4 tick and is valid when `done` is 1.
- R11: `done` is high for exactly the S5 tick. `req_ready` is 1 only in idle. A request presented while a cycle runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tick per half-state |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Transfer request, taken in idle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Transfer address; top bits pick the region |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | High while idle |
| done | output | 1 | One-tick completion pulse (S5) |
| done_err | output | 1 | Cycle ended in a bus error, valid with done |
| rd_data | output | DW | Read data captured at end of S4 |
| cfg_fast | input | NREG | Per-region fast termination enable |
| cfg_intack | input | NREG | Per-region internal acknowledge enable |
| cfg_waits | input | NREG*WW | Per-region wait-pair count |
| bus_addr | output | AW | External address |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_dout | output | DW | Write data to the bus |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | DW | Read data from the bus |
| bus_ack_n | input | 1 | Asynchronous slave acknowledge, active low |
| bus_berr_n | input | 1 | Asynchronous bus error, active low |

## Verification
The hardest situation to reach is a bus error that arrives after the acknowledge and is seen only in S3 or S4. The stimulus must also include the error arriving one tick too late to count. Because of the synchronizer lag, this window depends on the exact ticks at which the slave drives each pin. The bench drives both pins at tick offsets from the start of the cycle, randomly and in directed cases on both sides of the window's edge. It computes the wait-pair count and the error outcome from those offsets alone.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S0,
        ST_S1,
        ST_S2,
        ST_SW1,
        ST_SW2,
        ST_S3,
        ST_S4,
        ST_S5
    } bus_state_e;
endpackage

// File: rtl/bcs_sync.sv
// Two-flop synchronizer, one chain per bit.
module bcs_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        logic stab;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta <= 1'b0;
                stab <= 1'b0;
            end else begin
                meta <= d[i];
                stab <= meta;
            end
        end
        assign q[i] = stab;
    end
endmodule

// File: rtl/bcs_region_sel.sv
// Picks one region's configuration out of the flat per-region vectors.
module bcs_region_sel #(
    parameter int NREG = 4,
    parameter int WW   = 3,
    localparam int RB  = $clog2(NREG)
) (
    input  logic [RB-1:0]      region,
    input  logic [NREG-1:0]    cfg_fast,
    input  logic [NREG-1:0]    cfg_intack,
    input  logic [NREG*WW-1:0] cfg_waits,
    output logic               sel_fast,
    output logic               sel_int,
    output logic [WW-1:0]      sel_waits
);
    logic [WW-1:0] waits_arr [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        assign waits_arr[r] = cfg_waits[r*WW +: WW];
    end

    assign sel_fast  = cfg_fast[region];
    assign sel_int   = cfg_intack[region];
    assign sel_waits = waits_arr[region];
endmodule

// File: rtl/bcs_wait_ctr.sv
// Counts wait-state pairs; hit when the count equals the limit.
module bcs_wait_ctr #(
    parameter int WW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [WW-1:0] limit,
    output logic          hit
);
    logic [WW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = (cnt == limit);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int NREG = 4,
    parameter int WW   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               req_ready,
    output logic               done,
    output logic               done_err,
    output logic [DW-1:0]      rd_data,
    input  logic [NREG-1:0]    cfg_fast,
    input  logic [NREG-1:0]    cfg_intack,
    input  logic [NREG*WW-1:0] cfg_waits,
    output logic [AW-1:0]      bus_addr,
    output logic               bus_as_n,
    output logic               bus_ds_n,
    output logic               bus_rw,
    output logic [DW-1:0]      bus_dout,
    output logic               bus_dout_en,
    input  logic [DW-1:0]      bus_din,
    input  logic               bus_ack_n,
    input  logic               bus_berr_n
);
    localparam int RB = $clog2(NREG);

    bus_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdat_q;
    logic          write_q, fast_q, int_q, err_q;
    logic [WW-1:0] waits_q;

    logic          sel_fast, sel_int;
    logic [WW-1:0] sel_waits;
    logic [1:0]    sync_out;
    logic          ack_s, berr_s, wait_hit, term;
    logic          as_act, ds_act, in_decide;

    bcs_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({~bus_berr_n, ~bus_ack_n}),
        .q     (sync_out)
    );
    assign ack_s  = sync_out[0];
    assign berr_s = sync_out[1];

    bcs_region_sel #(.NREG(NREG), .WW(WW)) u_rsel (
        .region     (req_addr[AW-1 -: RB]),
        .cfg_fast   (cfg_fast),
        .cfg_intack (cfg_intack),
        .cfg_waits  (cfg_waits),
        .sel_fast   (sel_fast),
        .sel_int    (sel_int),
        .sel_waits  (sel_waits)
    );

    bcs_wait_ctr #(.WW(WW)) u_wctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == ST_S0),
        .inc   (state_q == ST_SW1),
        .limit (waits_q),
        .hit   (wait_hit)
    );

    assign in_decide = (state_q == ST_S2) || (state_q == ST_SW2);
    assign term      = ack_s || berr_s || (int_q && wait_hit);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_S0;
            ST_S0:   state_d = ST_S1;
            ST_S1:   state_d = fast_q ? ST_S4 : ST_S2;
            ST_S2:   state_d = term ? ST_S3 : ST_SW1;
            ST_SW1:  state_d = ST_SW2;
            ST_SW2:  state_d = term ? ST_S3 : ST_SW1;
            ST_S3:   state_d = ST_S4;
            ST_S4:   state_d = ST_S5;
            ST_S5:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state and cycle registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdat_q  <= '0;
            write_q <= 1'b0;
            fast_q  <= 1'b0;
            int_q   <= 1'b0;
            waits_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                write_q <= req_write;
                fast_q  <= sel_fast;
                int_q   <= sel_int;
                waits_q <= sel_waits;
            end
            if (state_q == ST_S0) begin
                err_q <= 1'b0;
            end else if (in_decide && berr_s) begin
                err_q <= 1'b1;
            end else if ((state_q == ST_S3 || state_q == ST_S4) && !fast_q && berr_s) begin
                err_q <= 1'b1;
            end
            if (state_q == ST_S4 && !write_q) begin
                rdat_q <= bus_din;
            end
        end
    end

    // outputs
    always_comb begin
        as_act = 1'b0;
        unique case (state_q)
            ST_S1, ST_S2, ST_SW1, ST_SW2, ST_S3, ST_S4: as_act = 1'b1;
            default:                                    as_act = 1'b0;
        endcase
        if (write_q) begin
            ds_act = !fast_q && (state_q == ST_S3 || state_q == ST_S4);
        end else begin
            ds_act = as_act;
        end
        bus_as_n    = !as_act;
        bus_ds_n    = !ds_act;
        bus_rw      = !(write_q && state_q != ST_IDLE);
        bus_dout_en = write_q && state_q != ST_IDLE && state_q != ST_S0;
        bus_dout    = wdata_q;
        bus_addr    = addr_q;
        req_ready   = (state_q == ST_IDLE);
        done        = (state_q == ST_S5);
        done_err    = (state_q == ST_S5) && err_q;
        rd_data     = rdat_q;
    end
endmodule

// File: rtl/bcs_checks.sv
module bcs_checks
    import bcs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_as_n,
    input logic       bus_ds_n,
    input logic       bus_rw,
    input logic       bus_dout_en,
    input logic       done,
    input logic       done_err,
    input logic       req_ready,
    input logic       fast_q,
    input bus_state_e state_q
);
    a_r8_ds_within_as: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ds_n |-> !bus_as_n);

    a_r9_dout_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_en |-> !bus_rw);

    a_r9_rw_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && !$past(bus_as_n)) |-> $stable(bus_rw));

    a_r11_done_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |-> done);

    a_r11_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    a_r7_fast_skips: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_q && state_q == ST_S1) |=> (state_q == ST_S4));
endmodule

bind bus_cycle_seq bcs_checks u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_as_n    (bus_as_n),
    .bus_ds_n    (bus_ds_n),
    .bus_rw      (bus_rw),
    .bus_dout_en (bus_dout_en),
    .done        (done),
    .done_err    (done_err),
    .req_ready   (req_ready),
    .fast_q      (fast_q),
    .state_q     (state_q)
);

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int NREG = 4;
    localparam int WW = 3;
    localparam int NONE = 99;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, bus_din = '0;
    logic req_ready, done, done_err, bus_as_n, bus_ds_n, bus_rw, bus_dout_en;
    logic [DW-1:0] rd_data, bus_dout;
    logic [AW-1:0] bus_addr;
    logic bus_ack_n = 1'b1, bus_berr_n = 1'b1;
    // region 0 external, 1 internal 2 pairs, 2 fast (waits 3 overridden), 3 internal 0 pairs
    logic [NREG-1:0] cfg_fast = 4'b0100;
    logic [NREG-1:0] cfg_intack = 4'b1010;
    logic [NREG*WW-1:0] cfg_waits = {3'd0, 3'd3, 3'd2, 3'd0};

    int checks = 0;
    int fails = 0;
    longint ticks = 0;

    always #2.5 clk = ~clk;

    bus_cycle_seq #(.AW(AW), .DW(DW), .NREG(NREG), .WW(WW)) uut (.*);

    always @(posedge clk) begin
        ticks <= ticks + 1;
        if (ticks > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000", ticks);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pairs(input int region, input int dack, input int dberr);
        int dt;
        if (region == 2) return 0;
        if (region == 1) return 2;
        if (region == 3) return 0;
        dt = (dack < dberr) ? dack : dberr;
        if (dt <= -1) return 0;
        return (dt + 2) / 2;
    endfunction

    function automatic bit exp_err(input int region, input int dack, input int dberr);
        int k;
        if (region == 2 || dberr == NONE) return 1'b0;
        k = exp_pairs(region, dack, dberr);
        return dberr <= 1 + 2 * k;
    endfunction

    // dack/dberr: pin driven low in tick 1+d counted from the S0 tick (0)
    task automatic run_cycle(input int region, input bit wr, input int dack, input int dberr,
                             input bit poke);
        int n, nd, as_cnt, ds_cnt, k, exp_as, exp_ds;
        bit rw_ok, dout_ok, addr_ok;
        logic [AW-1:0] a;
        logic [DW-1:0] wd, din;
        a   = {region[1:0], 14'($urandom)};
        wd  = 16'($urandom);
        din = 16'($urandom);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; bus_din = din;
        n = 0; nd = -1; as_cnt = 0; ds_cnt = 0; rw_ok = 1; dout_ok = 1; addr_ok = 1;
        while (nd < 0 && n < 64) begin
            @(negedge clk);
            req_valid = poke && (n == 2);
            if (poke) req_addr = ~a;
            if (n == 1 + dack) bus_ack_n = 1'b0;
            if (n == 1 + dberr) bus_berr_n = 1'b0;
            if (!bus_as_n) begin
                as_cnt++;
                if (bus_addr != a) addr_ok = 0;
            end
            if (!bus_ds_n) begin
                ds_cnt++;
                if (wr && (!bus_dout_en || bus_dout != wd)) dout_ok = 0;
            end
            if (bus_rw != !wr) rw_ok = 0;
            if (poke && n == 1) chk(req_ready == 0, "R11 ready low while busy", req_ready, 0);
            if (done) nd = n;
            n++;
        end
        k = exp_pairs(region, dack, dberr);
        chk(nd == ((region == 2) ? 3 : 5 + 2 * k),
            (region == 2) ? "R7 fast length" : (region[0] ? "R4 internal ack length" : "R2 R3 wait length"),
            nd, (region == 2) ? 3 : 5 + 2 * k);
        chk(done_err == exp_err(region, dack, dberr), "R5 R6 error flag", done_err,
            exp_err(region, dack, dberr));
        exp_as = (region == 2) ? 2 : 4 + 2 * k;
        exp_ds = wr ? ((region == 2) ? 0 : 2) : exp_as;
        chk(as_cnt == exp_as, "R8 address strobe ticks", as_cnt, exp_as);
        chk(ds_cnt == exp_ds, "R8 data strobe ticks", ds_cnt, exp_ds);
        chk(rw_ok && addr_ok, "R9 rw and address hold", {rw_ok, addr_ok}, 3);
        if (wr) chk(dout_ok, "R9 write data on strobe", dout_ok, 1);
        else chk(rd_data == din, "R10 read data", rd_data, din);
        bus_ack_n = 1'b1; bus_berr_n = 1'b1; req_valid = 1'b0;
        if (poke) begin
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk(bus_as_n == 1 && req_ready == 1, "R11 busy request ignored", bus_as_n, 1);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd1416));
        #1;
        chk(bus_as_n == 1 && bus_ds_n == 1 && bus_rw == 1, "R1 strobes idle", {bus_as_n, bus_ds_n, bus_rw}, 7);
        chk(done == 0 && req_ready == 1, "R1 done low ready high", {done, req_ready}, 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // directed: external ack timing around the synchronizer (R2, R3)
        run_cycle(0, 0, -1, NONE, 0);
        run_cycle(0, 0, 0, NONE, 0);
        run_cycle(0, 1, 1, NONE, 0);
        run_cycle(0, 0, 2, NONE, 0);
        // internal acknowledge (R4)
        run_cycle(1, 0, NONE, NONE, 0);
        run_cycle(3, 1, NONE, NONE, 0);
        // bus error at decision without ack (R5), late error edge (R6)
        run_cycle(0, 0, NONE, 1, 0);
        run_cycle(0, 0, 0, 3, 0);
        run_cycle(0, 0, 0, 4, 0);
        // fast termination, pins ignored (R7)
        run_cycle(2, 0, -1, -1, 0);
        run_cycle(2, 1, NONE, NONE, 0);
        // request while busy (R11)
        run_cycle(0, 1, 0, NONE, 1);
        for (int i = 0; i < 300; i++) begin
            int rg, da, db;
            rg = int'($urandom_range(0, 3));
            da = int'($urandom_range(0, 6)) - 1;
            db = ($urandom_range(0, 3) == 0) ? da + int'($urandom_range(0, 5)) - 1 : NONE;
            if (rg == 1 || rg == 3) begin da = NONE; db = NONE; end
            run_cycle(rg, 1'($urandom), da, db, 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule